// File: doc/BRIEF.md
# Selectable Error Event Counter with Snapshot

This block keeps a 16-bit saturating count of receive-side error events on an E1 line and presents it to software as two bytes. A mode input picks the event source. In one mode it counts reports carried in the spare bits: four spare-bit samples make up each CRC submultiframe, and the block counts a report when the four samples match one of two error codes. In the other mode it counts bit errors flagged by a pseudo-random sequence checker. Each source counts only while its own lock condition holds. An alarm-simulation input forces one count per submultiframe.

Software reads the count through a buffer, which works in one of two ways. In manual mode the buffer follows the live count until software requests a freeze. The freeze request snapshots the count and restarts the live counter. Reading the high byte ends the freeze. In timed mode a one-second tick loads the buffer, restarts the live counter and raises a flag. In both modes, an event that falls in the restart cycle counts toward the new period.

Top module: `err_evt_cnt`

## Requirements
- R1: After reset the live count and the buffer are 0, and freeze_o and sec_flag_o are low.
- R2: With prbs_mode_i=1, each cycle with prbs_err_i=1 adds one while prbs_sync_i=1. Errors are ignored while prbs_sync_i=0, and spare-bit reports never count in this mode.
- R3: With prbs_mode_i=0, the four spare bits of a submultiframe are taken on four sa_stb_i cycles. The first of these coincides with smf_start_i and forms the MSB. The count rises by one when the four-bit code is 0001 or 0011. Any other code, and any prbs_err_i pulse, adds nothing.
- R4: Spare-bit reports count only while crc_mf_i=1 and mf_lost_i=0.
- R5: Each smf_start_i cycle with alarm_sim_i=1 adds one, in either mode and regardless of the lock inputs.
- R6: The live count saturates at 0xFFFF and never wraps.
- R7: An event in the same cycle as a restart (freeze or tick) is not part of the snapshot, and the new count starts at 1.
- R8: In manual mode, while not frozen, the buffer takes the live count one cycle later. rd_data_o shows buffer bits 7:0 when rd_hi_i=0 and bits 15:8 when rd_hi_i=1.
- R9: In manual mode with freeze_o=0, a freeze_set_i cycle loads the buffer with the current count, restarts the live count and sets freeze_o. The buffer then holds while freeze_o=1.
- R10: A cycle with rd_stb_i=1 and rd_hi_i=1 clears freeze_o, and buffer tracking resumes. A low-byte read (rd_hi_i=0) leaves freeze_o set.
- R11: In timed mode, a sec_tick_i cycle loads the buffer with the count and restarts it. sec_flag_o pulses for one cycle on the following cycle. Between ticks the buffer holds, and freeze_set_i is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| prbs_mode_i | input | 1 | 1: count sequence bit errors; 0: count spare-bit reports |
| timed_mode_i | input | 1 | 1: one-second snapshot; 0: manual freeze |
| crc_mf_i | input | 1 | CRC multiframe operation active |
| mf_lost_i | input | 1 | Multiframe alignment lost |
| prbs_sync_i | input | 1 | Sequence checker locked |
| sa_stb_i | input | 1 | Spare-bit sample valid |
| smf_start_i | input | 1 | First frame of a submultiframe |
| sa_bit_i | input | 1 | Spare-bit value |
| prbs_err_i | input | 1 | Sequence bit error pulse |
| alarm_sim_i | input | 1 | Alarm simulation enable |
| sec_tick_i | input | 1 | One-second tick |
| freeze_set_i | input | 1 | Freeze request write |
| rd_stb_i | input | 1 | Register read strobe |
| rd_hi_i | input | 1 | Byte select: 1 high, 0 low |
| rd_data_o | output | 8 | Selected buffer byte |
| freeze_o | output | 1 | Freeze request bit |
| sec_flag_o | output | 1 | One-second flag pulse |

## Verification
The collision that matters is a counting event in the same cycle as a period restart. That restart is either the rising freeze request in manual mode or the second tick in timed mode. The bench drives a sequence error together with each kind of restart. It then checks that the snapshot holds only the earlier events and that the next period reports one more than the events sent after the restart. The check reads the buffer after the freeze is released or after the next tick.

// File: rtl/err_cnt_pkg.sv
package err_cnt_pkg;
  localparam int unsigned SA_LEN = 4;
  typedef logic [SA_LEN-1:0] sa_code_t;
  localparam sa_code_t CODE_ERR_A = 4'b0001;
  localparam sa_code_t CODE_ERR_B = 4'b0011;
endpackage

// File: rtl/sa_pattern_det.sv
module sa_pattern_det
  import err_cnt_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sa_stb_i,
  input  logic smf_start_i,
  input  logic sa_bit_i,
  output logic hit_o
);
  localparam int unsigned POS_W = $clog2(SA_LEN + 1);

  logic [POS_W-1:0]  pos_q;
  logic [SA_LEN-2:0] sh_q;
  sa_code_t          code;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pos_q <= '0;
      sh_q  <= '0;
    end else if (sa_stb_i && smf_start_i) begin
      pos_q <= POS_W'(1);
      sh_q  <= {{(SA_LEN-2){1'b0}}, sa_bit_i};
    end else if (sa_stb_i && pos_q != '0 && pos_q < POS_W'(SA_LEN)) begin
      pos_q <= pos_q + POS_W'(1);
      sh_q  <= {sh_q[SA_LEN-3:0], sa_bit_i};
    end
  end

  assign code  = {sh_q, sa_bit_i};
  // last sample of the submultiframe completes the code
  assign hit_o = sa_stb_i && !smf_start_i && (pos_q == POS_W'(SA_LEN-1)) &&
                 (code == CODE_ERR_A || code == CODE_ERR_B);
endmodule

// File: rtl/sat_counter.sv
module sat_counter #(
  parameter int unsigned W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         inc_i,
  input  logic         clr_i,
  output logic [W-1:0] cnt_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     cnt_o <= '0;
    else if (clr_i)                  cnt_o <= W'(inc_i);
    else if (inc_i && cnt_o != '1)   cnt_o <= cnt_o + W'(1);
  end
endmodule

// File: rtl/snap_buf.sv
module snap_buf #(
  parameter int unsigned W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         timed_i,
  input  logic         tick_i,
  input  logic         freeze_set_i,
  input  logic         hi_read_i,
  input  logic [W-1:0] cnt_i,
  output logic [W-1:0] snap_o,
  output logic         freeze_o,
  output logic         flag_o,
  output logic         clr_o
);
  logic freeze_rise;

  assign freeze_rise = !timed_i && freeze_set_i && !freeze_o;
  assign clr_o       = timed_i ? tick_i : freeze_rise;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      snap_o   <= '0;
      freeze_o <= 1'b0;
      flag_o   <= 1'b0;
    end else begin
      flag_o <= timed_i && tick_i;
      if (freeze_rise)    freeze_o <= 1'b1;
      else if (hi_read_i) freeze_o <= 1'b0;
      if (timed_i ? tick_i : !freeze_o) snap_o <= cnt_i;
    end
  end
endmodule

// File: rtl/err_evt_cnt.sv
module err_evt_cnt #(
  parameter int unsigned BYTE_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              prbs_mode_i,
  input  logic              timed_mode_i,
  input  logic              crc_mf_i,
  input  logic              mf_lost_i,
  input  logic              prbs_sync_i,
  input  logic              sa_stb_i,
  input  logic              smf_start_i,
  input  logic              sa_bit_i,
  input  logic              prbs_err_i,
  input  logic              alarm_sim_i,
  input  logic              sec_tick_i,
  input  logic              freeze_set_i,
  input  logic              rd_stb_i,
  input  logic              rd_hi_i,
  output logic [BYTE_W-1:0] rd_data_o,
  output logic              freeze_o,
  output logic              sec_flag_o
);
  localparam int unsigned CNT_W = 2 * BYTE_W;

  logic             sa_hit, inc_evt, clr_evt;
  logic [CNT_W-1:0] live_cnt, snap_q;

  sa_pattern_det u_sa (
    .clk_i, .rst_ni, .sa_stb_i, .smf_start_i, .sa_bit_i,
    .hit_o(sa_hit)
  );

  assign inc_evt = (!prbs_mode_i && crc_mf_i && !mf_lost_i && sa_hit) ||
                   (prbs_mode_i && prbs_sync_i && prbs_err_i) ||
                   (alarm_sim_i && smf_start_i);

  sat_counter #(.W(CNT_W)) u_cnt (
    .clk_i, .rst_ni, .inc_i(inc_evt), .clr_i(clr_evt), .cnt_o(live_cnt)
  );

  snap_buf #(.W(CNT_W)) u_buf (
    .clk_i, .rst_ni,
    .timed_i     (timed_mode_i),
    .tick_i      (sec_tick_i),
    .freeze_set_i,
    .hi_read_i   (rd_stb_i && rd_hi_i),
    .cnt_i       (live_cnt),
    .snap_o      (snap_q),
    .freeze_o,
    .flag_o      (sec_flag_o),
    .clr_o       (clr_evt)
  );

  assign rd_data_o = rd_hi_i ? snap_q[CNT_W-1:BYTE_W] : snap_q[BYTE_W-1:0];
endmodule

// File: rtl/err_evt_cnt_chk.sv
module err_evt_cnt_chk #(
  parameter int unsigned W = 16
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         prbs_mode_i,
  input logic         prbs_sync_i,
  input logic         alarm_sim_i,
  input logic         timed_mode_i,
  input logic         sec_tick_i,
  input logic         rd_stb_i,
  input logic         rd_hi_i,
  input logic         freeze_o,
  input logic         sec_flag_o,
  input logic         clr_evt,
  input logic [W-1:0] live_cnt,
  input logic [W-1:0] snap_q
);
  a_r2_unsync_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (prbs_mode_i && !prbs_sync_i && !alarm_sim_i && !clr_evt) |=> $stable(live_cnt));

  a_r6_no_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (live_cnt == '1 && !clr_evt) |=> live_cnt == '1);

  a_r7_restart_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_evt |=> live_cnt <= W'(1));

  a_r9_frozen_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (freeze_o && !timed_mode_i) |=> $stable(snap_q));

  a_r10_hi_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (freeze_o && rd_stb_i && rd_hi_i) |=> !freeze_o);

  a_r11_tick_snap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (timed_mode_i && sec_tick_i) |=> (sec_flag_o && snap_q == $past(live_cnt)));

  a_r11_flag_only_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(timed_mode_i && sec_tick_i) |=> !sec_flag_o);
endmodule

bind err_evt_cnt err_evt_cnt_chk #(.W(CNT_W)) u_chk (
  .clk_i, .rst_ni, .prbs_mode_i, .prbs_sync_i, .alarm_sim_i, .timed_mode_i,
  .sec_tick_i, .rd_stb_i, .rd_hi_i, .freeze_o, .sec_flag_o,
  .clr_evt(clr_evt), .live_cnt(live_cnt), .snap_q(snap_q)
);

// File: tb/err_evt_cnt_tb.sv
module err_evt_cnt_tb;
  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic prbs_mode_i = 0, timed_mode_i = 0, crc_mf_i = 0, mf_lost_i = 0;
  logic prbs_sync_i = 0, sa_stb_i = 0, smf_start_i = 0, sa_bit_i = 0;
  logic prbs_err_i = 0, alarm_sim_i = 0, sec_tick_i = 0, freeze_set_i = 0;
  logic rd_stb_i = 0, rd_hi_i = 0;
  logic [7:0] rd_data_o;
  logic freeze_o, sec_flag_o;

  int n_vec = 0;
  int n_bad = 0;
  bit done = 0;

  always #2 clk_i = ~clk_i;

  err_evt_cnt u_dut (.*);

  typedef struct packed {
    logic       mode;
    logic       sync;
    logic       crc;
    logic       lost;
    logic [3:0] pat;
    logic [7:0] reps;
    logic [15:0] exp;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VEC [NV] = '{
    '{1'b1, 1'b1, 1'b1, 1'b0, 4'b0001, 8'd5, 16'd5},  // R2 locked
    '{1'b1, 1'b0, 1'b1, 1'b0, 4'b0001, 8'd5, 16'd0},  // R2 unlocked
    '{1'b0, 1'b1, 1'b1, 1'b0, 4'b0001, 8'd3, 16'd3},  // R3 code 0001
    '{1'b0, 1'b0, 1'b1, 1'b0, 4'b0011, 8'd2, 16'd2},  // R3 code 0011
    '{1'b0, 1'b1, 1'b1, 1'b0, 4'b0111, 8'd3, 16'd0},  // R3 other code
    '{1'b0, 1'b1, 1'b1, 1'b0, 4'b1000, 8'd3, 16'd0},  // R3 bit order
    '{1'b0, 1'b1, 1'b1, 1'b0, 4'b1100, 8'd2, 16'd0},  // R3 bit order
    '{1'b0, 1'b1, 1'b0, 1'b0, 4'b0001, 8'd3, 16'd0},  // R4 no crc mf
    '{1'b0, 1'b1, 1'b1, 1'b1, 4'b0001, 8'd3, 16'd0}   // R4 mf lost
  };

  task automatic cyc(int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk_i);
      #1;
    end
  endtask

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic read16(output logic [15:0] v);
    rd_hi_i = 1'b0; #0.5;
    v[7:0] = rd_data_o;
    rd_hi_i = 1'b1; #0.5;
    v[15:8] = rd_data_o;
    rd_hi_i = 1'b0;
  endtask

  task automatic do_reset();
    {prbs_mode_i, timed_mode_i, crc_mf_i, mf_lost_i, prbs_sync_i} = '0;
    {sa_stb_i, smf_start_i, sa_bit_i, prbs_err_i, alarm_sim_i} = '0;
    {sec_tick_i, freeze_set_i, rd_stb_i, rd_hi_i} = '0;
    rst_ni = 1'b0;
    cyc(2);
    rst_ni = 1'b1;
    cyc(1);
  endtask

  task automatic send_smf(logic [3:0] pat, logic err);
    for (int i = 0; i < 4; i++) begin
      sa_stb_i    = 1'b1;
      smf_start_i = (i == 0);
      sa_bit_i    = pat[3-i];
      prbs_err_i  = (i == 0) && err;
      cyc();
    end
    {sa_stb_i, smf_start_i, sa_bit_i, prbs_err_i} = '0;
    cyc();
  endtask

  task automatic errs(int n);
    prbs_err_i = 1'b1;
    cyc(n);
    prbs_err_i = 1'b0;
  endtask

  task automatic pulse_hi_read(logic hi);
    rd_hi_i = hi; rd_stb_i = 1'b1;
    cyc();
    rd_stb_i = 1'b0; rd_hi_i = 1'b0;
  endtask

  initial begin
    #(4 * 190000);
    if (!done) begin
      n_vec++; n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] v;
    // R1 reset state
    do_reset();
    read16(v);
    chk("R1 buffer", v, 16'h0);
    chk("R1 freeze", {15'b0, freeze_o}, 16'h0);
    chk("R1 flag", {15'b0, sec_flag_o}, 16'h0);

    // table of source and gating cases, manual mode, unfrozen
    for (int k = 0; k < NV; k++) begin
      do_reset();
      prbs_mode_i = VEC[k].mode;
      prbs_sync_i = VEC[k].sync;
      crc_mf_i    = VEC[k].crc;
      mf_lost_i   = VEC[k].lost;
      for (int r = 0; r < int'(VEC[k].reps); r++) send_smf(VEC[k].pat, 1'b1);
      cyc(2);
      read16(v);
      chk(VEC[k].mode ? "R2 table" : "R3/R4 table", v, VEC[k].exp);
    end

    // R5 alarm simulation, ungated
    do_reset();
    prbs_mode_i = 1'b1; alarm_sim_i = 1'b1;
    for (int i = 0; i < 3; i++) begin smf_start_i = 1'b1; cyc(); smf_start_i = 1'b0; cyc(); end
    prbs_mode_i = 1'b0; crc_mf_i = 1'b0;
    for (int i = 0; i < 2; i++) begin smf_start_i = 1'b1; cyc(); smf_start_i = 1'b0; cyc(); end
    alarm_sim_i = 1'b0;
    cyc(2);
    read16(v);
    chk("R5 alarm", v, 16'd5);

    // R8 one-cycle lag and byte select
    do_reset();
    prbs_mode_i = 1'b1; prbs_sync_i = 1'b1;
    errs(1);
    read16(v);
    chk("R8 lag before", v, 16'd0);
    cyc();
    read16(v);
    chk("R8 lag after", v, 16'd1);
    errs(299);
    cyc(2);
    rd_hi_i = 1'b0; #0.5;
    chk("R8 low byte", {8'h0, rd_data_o}, 16'h002C);
    rd_hi_i = 1'b1; #0.5;
    chk("R8 high byte", {8'h0, rd_data_o}, 16'h0001);
    rd_hi_i = 1'b0;

    // R9 R10 R7 freeze with coincident event
    do_reset();
    prbs_mode_i = 1'b1; prbs_sync_i = 1'b1;
    errs(6);
    cyc(2);
    freeze_set_i = 1'b1; prbs_err_i = 1'b1;
    cyc();
    freeze_set_i = 1'b0; prbs_err_i = 1'b0;
    chk("R9 freeze set", {15'b0, freeze_o}, 16'h1);
    read16(v);
    chk("R7 snapshot excludes event", v, 16'd6);
    errs(3);
    cyc(2);
    read16(v);
    chk("R9 buffer holds", v, 16'd6);
    pulse_hi_read(1'b0);
    chk("R10 low read keeps freeze", {15'b0, freeze_o}, 16'h1);
    pulse_hi_read(1'b1);
    chk("R10 high read releases", {15'b0, freeze_o}, 16'h0);
    cyc();
    read16(v);
    chk("R7 new period starts at 1", v, 16'd4);

    // R11 R7 timed mode
    do_reset();
    timed_mode_i = 1'b1; prbs_mode_i = 1'b1; prbs_sync_i = 1'b1;
    errs(7);
    cyc(2);
    read16(v);
    chk("R11 buffer idle", v, 16'd0);
    sec_tick_i = 1'b1; prbs_err_i = 1'b1;
    cyc();
    sec_tick_i = 1'b0; prbs_err_i = 1'b0;
    chk("R11 flag", {15'b0, sec_flag_o}, 16'h1);
    read16(v);
    chk("R11 tick snapshot", v, 16'd7);
    cyc();
    chk("R11 flag one cycle", {15'b0, sec_flag_o}, 16'h0);
    freeze_set_i = 1'b1;
    cyc();
    freeze_set_i = 1'b0;
    chk("R11 freeze ignored", {15'b0, freeze_o}, 16'h0);
    errs(2);
    cyc(2);
    read16(v);
    chk("R11 holds between ticks", v, 16'd7);
    sec_tick_i = 1'b1;
    cyc();
    sec_tick_i = 1'b0;
    read16(v);
    chk("R7 timed new period", v, 16'd3);

    // R6 saturation
    do_reset();
    prbs_mode_i = 1'b1; prbs_sync_i = 1'b1;
    errs(65540);
    cyc(2);
    read16(v);
    chk("R6 saturate", v, 16'hFFFF);
    errs(1);
    cyc(2);
    read16(v);
    chk("R6 no wrap", v, 16'hFFFF);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule